// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretch and Low-Voltage Warning

This block turns two digital comparator outputs into a clean system reset and an early low-supply interrupt. One input is high while the supply sits under the reset threshold. The other is high while the supply sits under a higher warning threshold. Both inputs pass through a two-stage synchronizer before any logic uses them.

While the synchronized reset comparator is active, the reset output stays high. After the comparator clears, a stabilization counter must run a fixed number of cycles before reset is released. Any new dip during that count forces reset high again and restarts the count from zero.

A one-register control port holds an interrupt-enable bit and a sticky warning flag. The flag records every warning, whether or not the interrupt is enabled. Software clears it by writing zero to it. A warning request leaves the block with a fixed vector and the highest priority code.

Top module: `pfw_supervisor`

## Requirements
- R1: `sys_rst_o` is 1 from the third rising edge after `below_rst_i` goes high, and stays 1 for as long as the input remains high.
- R2: After `below_rst_i` falls, `sys_rst_o` stays 1 through the 65,537th rising edge and is 0 after the 65,538th: two synchronizer stages, then exactly 65,536 stabilization cycles.
- R3: A dip of `below_rst_i` during the stabilization count, even one cycle long, keeps reset asserted. The count then restarts from zero, so release again comes 65,538 edges after the dip ends.
- R4: `irq_req_o` is 1 only when the synchronized warning input is active and the enable bit (register bit 5) is 1. It rises on the third edge after `below_warn_i` rises, and it is 0 one edge after the enable bit has been written 0.
- R5: The warning flag (register bit 4) is set on the third edge after `below_warn_i` goes high, even when the enable bit is 0. A single-cycle input pulse is enough to set it.
- R6: The flag stays set until a write with bit 4 equal to 0. Writing 1 to bit 4 never sets the flag.
- R7: If a warning is active in the same cycle as a clearing write, the flag stays 1.
- R8: While `irq_req_o` is 1, `irq_vec_o` is 0x0033 and `irq_prio_o` is all ones. Both are 0 otherwise.
- R9: While `sys_rst_o` is 1, the enable bit is 0 and writes are ignored. The flag keeps its value through a supply reset and can still be set.
- R10: `reg_rdata` carries the enable bit at bit 5 and the flag at bit 4. All other bits read 0. A write lands on the first rising edge at which `reg_wr` is 1.
- R11: While `rst` is 1, `sys_rst_o` is 1, `irq_req_o` is 0 and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initialization reset |
| below_rst_i | input | 1 | Comparator: supply below reset threshold |
| below_warn_i | input | 1 | Comparator: supply below warning threshold |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data (bit 5 enable, bit 4 flag clear) |
| reg_rdata | output | 8 | Control register contents |
| sys_rst_o | output | 1 | System reset, active high |
| irq_req_o | output | 1 | Warning interrupt request |
| irq_vec_o | output | 16 | Interrupt vector address |
| irq_prio_o | output | 2 | Interrupt priority code |

## Verification
The flag-setting path and the software clear path can meet on the same edge. The bench provokes this with a one-cycle warning pulse and places a clearing write on exactly the third edge after the pulse starts, where the synchronized warning reaches the flag. The flag is judged to read 1 there. A repeat write one edge later, when the warning is gone, is judged to clear it. A second overlap is a supply dip arriving in the middle of the stabilization count. It is judged by whether release moves to a full count measured from the end of the dip.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  // Register field positions, shared by the top, the register and the checker
  localparam int unsigned REG_W        = 8;
  localparam int unsigned EN_POS       = 5;
  localparam int unsigned FLAG_POS     = 4;
  localparam int unsigned VECTOR_W     = 16;
  localparam logic [15:0] WARN_VECTOR  = 16'h0033;

  typedef struct packed {
    logic en;
    logic flag;
  } pfw_ctrl_t;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfw_stab_timer.sv
module pfw_stab_timer #(
  parameter int unsigned STAB_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic low,
  output logic hold
);
  localparam int unsigned CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  // Any low sample restarts the count and holds reset
  always_ff @(posedge clk) begin
    if (rst || low) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold) begin
      if (cnt == LAST) hold <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfw_ctrl_reg.sv
module pfw_ctrl_reg
  import pfw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hold,
  input  logic      warn,
  input  logic      wr,
  input  logic      wr_en,
  input  logic      wr_flag,
  output pfw_ctrl_t ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (hold)    ctrl.en <= 1'b0;
      else if (wr) ctrl.en <= wr_en;
      // Set has priority over a software clear in the same cycle
      if (warn)                           ctrl.flag <= 1'b1;
      else if (wr && !hold && !wr_flag)   ctrl.flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pfw_irq_out.sv
module pfw_irq_out #(
  parameter int unsigned    VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_ADDR = 16'h0033,
  parameter int unsigned    PRIO_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warn,
  input  logic              en,
  input  logic              hold,
  output logic              irq,
  output logic [VEC_W-1:0]  vec,
  output logic [PRIO_W-1:0] prio
);
  logic fire;
  assign fire = warn && en && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      vec  <= '0;
      prio <= '0;
    end else begin
      irq  <= fire;
      vec  <= fire ? VEC_ADDR : '0;
      prio <= fire ? '1 : '0;
    end
  end
endmodule

// File: rtl/pfw_supervisor.sv
module pfw_supervisor
  import pfw_pkg::*;
#(
  parameter int unsigned      STAB_CYCLES = 65536,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      DATA_W      = REG_W,
  parameter int unsigned      EN_BIT      = EN_POS,
  parameter int unsigned      FLAG_BIT    = FLAG_POS,
  parameter int unsigned      VEC_W       = VECTOR_W,
  parameter logic [VEC_W-1:0] VEC_ADDR    = WARN_VECTOR,
  parameter int unsigned      PRIO_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              below_rst_i,
  input  logic              below_warn_i,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_rst_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [PRIO_W-1:0] irq_prio_o
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << FLAG_BIT);

  logic      low_s;
  logic      warn_s;
  logic      hold;
  pfw_ctrl_t ctrl;
  logic      unused_wdata;

  pfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_rst (
    .clk(clk), .rst(rst), .d(below_rst_i), .q(low_s)
  );

  pfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_warn (
    .clk(clk), .rst(rst), .d(below_warn_i), .q(warn_s)
  );

  pfw_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .low(low_s), .hold(hold)
  );

  pfw_ctrl_reg i_ctrl (
    .clk(clk), .rst(rst), .hold(hold), .warn(warn_s),
    .wr(reg_wr), .wr_en(reg_wdata[EN_BIT]), .wr_flag(reg_wdata[FLAG_BIT]),
    .ctrl(ctrl)
  );

  pfw_irq_out #(.VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR), .PRIO_W(PRIO_W)) i_irq (
    .clk(clk), .rst(rst), .warn(warn_s), .en(ctrl.en), .hold(hold),
    .irq(irq_req_o), .vec(irq_vec_o), .prio(irq_prio_o)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[EN_BIT]   = ctrl.en;
    reg_rdata[FLAG_BIT] = ctrl.flag;
  end

  assign sys_rst_o    = hold;
  assign unused_wdata = ^(reg_wdata & ~FIELD_MASK);
endmodule

// File: rtl/pfw_checker.sv
module pfw_checker #(
  parameter int unsigned      STAB_CYCLES = 65536,
  parameter int unsigned      DATA_W      = 8,
  parameter int unsigned      EN_BIT      = 5,
  parameter int unsigned      FLAG_BIT    = 4,
  parameter int unsigned      VEC_W       = 16,
  parameter logic [VEC_W-1:0] VEC_ADDR    = 16'h0033,
  parameter int unsigned      PRIO_W      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              low_s,
  input logic              warn_s,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sys_rst_o,
  input logic              irq_req_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic [PRIO_W-1:0] irq_prio_o
);
  localparam int unsigned CW = $clog2(STAB_CYCLES + 2) + 1;
  logic [CW-1:0] run;

  // Cycles spent in reset with the supply good, counted independently
  always_ff @(posedge clk) begin
    if (rst || low_s)                          run <= '0;
    else if (sys_rst_o && run != {CW{1'b1}})   run <= run + 1'b1;
  end

  a_r1_rst_while_low: assert property (@(posedge clk) disable iff (rst)
    low_s |=> sys_rst_o);

  a_r2_release_after_count: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> (run == CW'(STAB_CYCLES)));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> ($past(reg_rdata[EN_BIT]) && $past(warn_s)));

  a_r5_flag_sets: assert property (@(posedge clk) disable iff (rst)
    warn_s |=> reg_rdata[FLAG_BIT]);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_rdata[FLAG_BIT]) |->
      $past(reg_wr && !reg_wdata[FLAG_BIT] && !sys_rst_o && !warn_s));

  a_r8_vector_on: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (irq_vec_o == VEC_ADDR && irq_prio_o == {PRIO_W{1'b1}}));

  a_r8_vector_off: assert property (@(posedge clk) disable iff (rst)
    !irq_req_o |-> (irq_vec_o == '0 && irq_prio_o == '0));

  a_r9_enable_off_in_rst: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !reg_rdata[EN_BIT]);
endmodule

bind pfw_supervisor pfw_checker #(
  .STAB_CYCLES(STAB_CYCLES), .DATA_W(DATA_W), .EN_BIT(EN_BIT),
  .FLAG_BIT(FLAG_BIT), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR), .PRIO_W(PRIO_W)
) i_chk (
  .clk(clk), .rst(rst), .low_s(low_s), .warn_s(warn_s),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .sys_rst_o(sys_rst_o), .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o), .irq_prio_o(irq_prio_o)
);

// File: tb/test_pfw_supervisor.sv
module test_pfw_supervisor;
  localparam int STAB = 65536;
  localparam logic [7:0] EN = 8'h20;
  localparam logic [7:0] FL = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below_rst_i = 1'b1;
  logic below_warn_i = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sys_rst_o, irq_req_o;
  logic [15:0] irq_vec_o;
  logic [1:0] irq_prio_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfw_supervisor i_pfw_supervisor (
    .clk(clk), .rst(rst), .below_rst_i(below_rst_i), .below_warn_i(below_warn_i),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_o(sys_rst_o), .irq_req_o(irq_req_o),
    .irq_vec_o(irq_vec_o), .irq_prio_o(irq_prio_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One write, captured on the next rising edge; returns at the following negedge
  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  initial begin
    step(3);
    chk("R11 reset rst_o", 32'(sys_rst_o), 1);
    chk("R11 reset rdata", 32'(reg_rdata), 0);
    chk("R11 reset irq", 32'(irq_req_o), 0);
    rst = 1'b0;
    step(10);
    chk("R1 held while low", 32'(sys_rst_o), 1);

    // R9: writes ignored, flag still set, during supply reset
    below_warn_i = 1'b1; step(4); below_warn_i = 1'b0; step(3);
    wr(EN);
    chk("R9 flag set, enable blocked", 32'(reg_rdata), 32'(FL));
    chk("R9 irq off in reset", 32'(irq_req_o), 0);
    wr(8'h00);
    chk("R9 clear ignored in reset", 32'(reg_rdata), 32'(FL));

    // R2: exact release
    below_rst_i = 1'b0;
    step(STAB + 1);
    chk("R2 still held at edge 65537", 32'(sys_rst_o), 1);
    step(1);
    chk("R2 released at edge 65538", 32'(sys_rst_o), 0);
    chk("R9 flag survives reset", 32'(reg_rdata), 32'(FL));

    // R6 / R10
    wr(EN | FL);
    chk("R10 enable and flag", 32'(reg_rdata), 32'(EN | FL));
    wr(EN);
    chk("R6 clear by writing 0", 32'(reg_rdata), 32'(EN));
    wr(8'hFF);
    chk("R6 writing 1 no set / R10 spare bits", 32'(reg_rdata), 32'(EN));

    // R4 / R8 / R5 with enable
    below_warn_i = 1'b1;
    step(2);
    chk("R4 not yet after 2 edges", 32'(irq_req_o), 0);
    step(1);
    chk("R4 irq after 3 edges", 32'(irq_req_o), 1);
    chk("R8 vector", 32'(irq_vec_o), 32'h33);
    chk("R8 priority", 32'(irq_prio_o), 3);
    chk("R5 flag set", 32'(reg_rdata), 32'(EN | FL));
    wr(8'h00);
    chk("R7 clear loses to active warning", 32'(reg_rdata), 32'(FL));
    step(1);
    chk("R4 irq off after disable", 32'(irq_req_o), 0);
    chk("R8 vector off", 32'(irq_vec_o), 0);
    chk("R8 priority off", 32'(irq_prio_o), 0);

    // R5: single-cycle pulse with enable 0
    below_warn_i = 1'b0; step(3);
    wr(8'h00);
    chk("R6 clear after warning gone", 32'(reg_rdata), 0);
    below_warn_i = 1'b1; step(1); below_warn_i = 1'b0; step(2);
    chk("R5 pulse sets flag, enable 0", 32'(reg_rdata), 32'(FL));
    chk("R4 no irq with enable 0", 32'(irq_req_o), 0);
    step(2);
    wr(8'h00);
    chk("R6 clear", 32'(reg_rdata), 0);

    // R7: clearing write on the exact setting edge
    below_warn_i = 1'b1; step(1); below_warn_i = 1'b0; step(1);
    wr(8'h00);
    chk("R7 set wins over clear", 32'(reg_rdata), 32'(FL));
    wr(8'h00);
    chk("R7 next clear succeeds", 32'(reg_rdata), 0);

    // R1 / R9: reassert with enable set
    wr(EN);
    chk("R10 enable", 32'(reg_rdata), 32'(EN));
    below_rst_i = 1'b1;
    step(2);
    chk("R1 not before 3 edges", 32'(sys_rst_o), 0);
    step(1);
    chk("R1 asserted after 3 edges", 32'(sys_rst_o), 1);
    step(1);
    chk("R9 enable cleared by reset", 32'(reg_rdata), 0);

    // R3: dip during the count restarts it
    below_rst_i = 1'b0;
    step(30000);
    chk("R2 held mid-count", 32'(sys_rst_o), 1);
    below_rst_i = 1'b1; step(1); below_rst_i = 1'b0;
    step(STAB + 1);
    chk("R3 count restarted after dip", 32'(sys_rst_o), 1);
    step(1);
    chk("R3 release after full recount", 32'(sys_rst_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule